// File: doc/BRIEF.md
# Buffered Input Capture Channel

This block is one input-capture channel of a timer. It watches a pin that is asynchronous to the clock, brings it into the clock domain through a synchroniser, and detects the edge type chosen by a 2-bit edge-mode field. On each accepted edge it stores the current value of an external free-running counter.

Captures go into a two-deep queue. The front register receives each new timestamp. The register behind it holds the previous one. An interrupt flag is raised once both registers hold data.

Software reads the two registers through read strobes. Each accepted read empties that register. The flag is cleared by writing a one to it. In no-overwrite mode a full queue stays frozen until software has drained both registers. Any order of the two reads and the flag clear works, even when edges arrive in between, and later edges still raise the flag.

Top module: `icapBufChannel`

## Requirements
- R1: After reset, capValue and holdValue read 0, capFlag is 0, the edge mode is off and both registers are empty.
- R2: Edge mode codes: 2'b00 off (no capture), 2'b01 rising only, 2'b10 falling only, 2'b11 both. pinIn passes through two flip-flops and an edge register before detection. The value stored is the timerCount present at the third rising clock edge after pinIn changes.
- R3: Any edge-mode write empties both registers and clears the no-overwrite lock. It leaves capFlag unchanged. An edge detected in the same cycle as this write is dropped.
- R4: An accepted edge while both registers are empty loads the counter into capValue and does not set capFlag.
- R5: An accepted edge while at least one register holds data sets capFlag. If the capture register holds data, its value moves into holdValue first. The new count always goes into capValue.
- R6: With noOverwrite high, once both registers have been filled, no edge changes either register until both have been read.
- R7: A read strobe empties its register in the cycle it is asserted. An edge in the same cycle as a capture read loads capValue without moving the value just read into holdValue.
- R8: flagClrWr with flagClrData=1 clears capFlag, and flagClrData=0 has no effect. A flag set in the same cycle as a clear wins.
- R9: For any order of the two reads and the flag clear, with edges arriving between them, later accepted edges with data present set capFlag again.
- R10: With noOverwrite low, an edge on a full queue shifts capValue into holdValue and loads the new count into capValue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| timerCount | input | 16 | Free-running counter value to capture |
| pinIn | input | 1 | Asynchronous capture pin |
| edgeSelWr | input | 1 | Strobe: write the edge-mode field |
| edgeSelData | input | 2 | Edge-mode code to write |
| noOverwrite | input | 1 | Freeze a full queue until both registers are read |
| capRdStb | input | 1 | Strobe: capture register read accepted |
| holdRdStb | input | 1 | Strobe: holding register read accepted |
| flagClrWr | input | 1 | Strobe: flag write |
| flagClrData | input | 1 | Flag write data (1 clears) |
| capValue | output | 16 | Capture register |
| holdValue | output | 16 | Holding register |
| capFlag | output | 1 | Capture interrupt flag |

## Verification
The bench aims edges at the exact cycles of reads, flag clears and edge-mode writes. A design that resolved those collisions the wrong way would lose the flag, copy a just-read value into the holding register, or capture during an enable. It runs the no-overwrite drain in several orders with blocked edges in between. A design that stayed locked, or that unlocked after a single read, would stop raising the flag or overwrite unread data. It also checks that the first edge after emptying is silent. A one-deep shortcut would flag too early.

// File: rtl/icapPkg.sv
package icapPkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edgeModeT;

  typedef struct packed {
    logic loadCap;
    logic shiftHold;
  } capStrobeT;
endpackage

// File: rtl/icapEdgeDetect.sv
module icapEdgeDetect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic pinRise,
  output logic pinFall
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic pinPrev;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : gSync
      if (i == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncChain[i] <= 1'b0;
          else       syncChain[i] <= pinIn;
      end else begin : gRest
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncChain[i] <= 1'b0;
          else       syncChain[i] <= syncChain[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) pinPrev <= 1'b0;
    else       pinPrev <= syncChain[LAST];

  assign pinRise = syncChain[LAST] & ~pinPrev;
  assign pinFall = ~syncChain[LAST] & pinPrev;

  // R2: a rising edge can not be reported twice in a row
  a_r2_no_double_rise: assert property (@(posedge clk) disable iff (!rstN)
    pinRise |=> !pinRise);
  a_r2_no_double_fall: assert property (@(posedge clk) disable iff (!rstN)
    pinFall |=> !pinFall);
endmodule

// File: rtl/icapControl.sv
module icapControl
  import icapPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      pinRise,
  input  logic      pinFall,
  input  logic      edgeSelWr,
  input  logic [1:0] edgeSelData,
  input  logic      noOverwrite,
  input  logic      capRdStb,
  input  logic      holdRdStb,
  input  logic      flagClrWr,
  input  logic      flagClrData,
  output capStrobeT strobes,
  output logic      capFlag
);
  edgeModeT edgeMode;
  logic capFull, holdFull, lockQ;
  logic edgeEv, capLeft, holdLeft, lockLeft, accept, haveData, flagSet, flagClr;

  always_comb begin
    case (edgeMode)
      EDGE_RISE: edgeEv = pinRise;
      EDGE_FALL: edgeEv = pinFall;
      EDGE_ANY:  edgeEv = pinRise | pinFall;
      default:   edgeEv = 1'b0;
    endcase
    capLeft   = capFull & ~capRdStb;
    holdLeft  = holdFull & ~holdRdStb;
    lockLeft  = lockQ & (capLeft | holdLeft);
    accept    = edgeEv & ~edgeSelWr & ~(noOverwrite & lockLeft);
    haveData  = capLeft | holdLeft;
    flagSet   = accept & haveData;
    flagClr   = flagClrWr & flagClrData;
    strobes.loadCap   = accept;
    strobes.shiftHold = accept & capLeft;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeMode <= EDGE_OFF;
      capFull  <= 1'b0;
      holdFull <= 1'b0;
      lockQ    <= 1'b0;
    end else if (edgeSelWr) begin
      edgeMode <= edgeModeT'(edgeSelData);
      capFull  <= 1'b0;
      holdFull <= 1'b0;
      lockQ    <= 1'b0;
    end else if (accept) begin
      capFull  <= 1'b1;
      holdFull <= holdLeft | capLeft;
      lockQ    <= haveData;
    end else begin
      capFull  <= capLeft;
      holdFull <= holdLeft;
      lockQ    <= lockLeft;
    end
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)        capFlag <= 1'b0;
    else if (flagSet) capFlag <= 1'b1;
    else if (flagClr) capFlag <= 1'b0;

  // R3: a mode write leaves the queue empty
  a_r3_mode_write_empties: assert property (@(posedge clk) disable iff (!rstN)
    edgeSelWr |=> (!capFull && !holdFull && !lockQ));
  // R4: an edge into an empty queue leaves the flag as it was
  a_r4_first_edge_silent: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadCap && !capFull && !holdFull && !(flagClrWr && flagClrData))
      |=> capFlag == $past(capFlag));
  // R6: a full, unread queue in no-overwrite mode takes no edge
  a_r6_frozen_when_full: assert property (@(posedge clk) disable iff (!rstN)
    (noOverwrite && capFull && holdFull && !capRdStb && !holdRdStb) |-> !strobes.loadCap);
  // R8: a clear with no competing set drops the flag
  a_r8_clear_works: assert property (@(posedge clk) disable iff (!rstN)
    (flagClrWr && flagClrData && !strobes.loadCap) |=> !capFlag);
  // R8: set wins over clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadCap && (capLeft || holdLeft)) |=> capFlag);
endmodule

// File: rtl/icapDatapath.sv
module icapDatapath
  import icapPkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  capStrobeT        strobes,
  input  logic [WIDTH-1:0] timerCount,
  output logic [WIDTH-1:0] capValue,
  output logic [WIDTH-1:0] holdValue
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capValue  <= '0;
      holdValue <= '0;
    end else begin
      if (strobes.shiftHold) holdValue <= capValue;
      if (strobes.loadCap)   capValue  <= timerCount;
    end
  end

  // R5: the shifted value is the old capture value
  a_r5_shift_carries_old: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shiftHold |=> holdValue == $past(capValue));
  // R6: without a load the capture register holds still
  a_r6_cap_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadCap |=> $stable(capValue));
  // R7: without a shift the holding register holds still
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.shiftHold |=> $stable(holdValue));
endmodule

// File: rtl/icapBufChannel.sv
module icapBufChannel
  import icapPkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] timerCount,
  input  logic             pinIn,
  input  logic             edgeSelWr,
  input  logic [1:0]       edgeSelData,
  input  logic             noOverwrite,
  input  logic             capRdStb,
  input  logic             holdRdStb,
  input  logic             flagClrWr,
  input  logic             flagClrData,
  output logic [WIDTH-1:0] capValue,
  output logic [WIDTH-1:0] holdValue,
  output logic             capFlag
);
  logic pinRise, pinFall;
  capStrobeT strobes;

  icapEdgeDetect #(.SYNC_STAGES(SYNC_STAGES)) uEdge (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .pinRise(pinRise), .pinFall(pinFall)
  );

  icapControl uCtrl (
    .clk(clk), .rstN(rstN), .pinRise(pinRise), .pinFall(pinFall),
    .edgeSelWr(edgeSelWr), .edgeSelData(edgeSelData), .noOverwrite(noOverwrite),
    .capRdStb(capRdStb), .holdRdStb(holdRdStb),
    .flagClrWr(flagClrWr), .flagClrData(flagClrData),
    .strobes(strobes), .capFlag(capFlag)
  );

  icapDatapath #(.WIDTH(WIDTH)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .timerCount(timerCount),
    .capValue(capValue), .holdValue(holdValue)
  );
endmodule

// File: tb/tb_icapBufChannel.sv
module tb_icapBufChannel;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] timerCount = 16'h1234;
  logic        pinIn = 1'b0;
  logic        edgeSelWr = 1'b0;
  logic [1:0]  edgeSelData = 2'b00;
  logic        noOverwrite = 1'b0;
  logic        capRdStb = 1'b0;
  logic        holdRdStb = 1'b0;
  logic        flagClrWr = 1'b0;
  logic        flagClrData = 1'b0;
  logic [15:0] capValue, holdValue;
  logic        capFlag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string curReq = "R1";

  always #2 clk = ~clk;

  icapBufChannel dut (.*);

  always @(negedge clk) timerCount <= timerCount + 16'd3;

  // behavioural reference model
  logic [15:0] mCap = 0, mHold = 0;
  bit mCapFull = 0, mHoldFull = 0, mLock = 0, mFlag = 0;
  bit mS1 = 0, mS2 = 0, mPrev = 0;
  logic [1:0] mMode = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mCap = 0; mHold = 0; mCapFull = 0; mHoldFull = 0; mLock = 0; mFlag = 0;
      mS1 = 0; mS2 = 0; mPrev = 0; mMode = 0;
    end else begin
      bit ev, capE, holdE, lockE, take;
      case (mMode)
        2'b01:   ev = mS2 && !mPrev;
        2'b10:   ev = !mS2 && mPrev;
        2'b11:   ev = mS2 != mPrev;
        default: ev = 0;
      endcase
      capE  = mCapFull && !capRdStb;
      holdE = mHoldFull && !holdRdStb;
      lockE = mLock && (capE || holdE);
      take  = ev && !edgeSelWr && !(noOverwrite && lockE);
      if (take && (capE || holdE)) mFlag = 1;
      else if (flagClrWr && flagClrData) mFlag = 0;
      if (edgeSelWr) begin
        mMode = edgeSelData; mCapFull = 0; mHoldFull = 0; mLock = 0;
      end else if (take) begin
        if (capE) mHold = mCap;
        mHoldFull = capE || holdE;
        mLock = capE || holdE;
        mCap = timerCount; mCapFull = 1;
      end else begin
        mCapFull = capE; mHoldFull = holdE; mLock = lockE;
      end
      mPrev = mS2; mS2 = mS1; mS1 = pinIn;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rstN && !finished) begin
    chk({curReq, " model cap"}, capValue, mCap);
    chk({curReq, " model hold"}, holdValue, mHold);
    chk({curReq, " model flag"}, capFlag, mFlag);
  end

  task automatic pinTo(bit v);
    pinIn = v;
    repeat (5) @(negedge clk);
  endtask
  task automatic setMode(logic [1:0] m);
    edgeSelData = m; edgeSelWr = 1; @(negedge clk); edgeSelWr = 0;
  endtask
  task automatic clrFlag(bit d);
    flagClrData = d; flagClrWr = 1; @(negedge clk); flagClrWr = 0;
  endtask
  task automatic rdCap();
    capRdStb = 1; @(negedge clk); capRdStb = 0;
  endtask
  task automatic rdHold();
    holdRdStb = 1; @(negedge clk); holdRdStb = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] s1, s2, c, h;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 cap", capValue, 0); chk("R1 hold", holdValue, 0); chk("R1 flag", capFlag, 0);

    curReq = "R2";
    pinTo(1); pinTo(0);
    chk("R2 off mode", capValue, 0);

    curReq = "R4";
    setMode(2'b01);
    pinTo(1);
    chk("R4 first edge no flag", capFlag, 0);
    s1 = capValue;
    pinTo(0);
    chk("R2 falling ignored in rise mode", capValue, s1);

    curReq = "R5";
    pinTo(1);
    chk("R5 flag set", capFlag, 1);
    chk("R5 hold gets old cap", holdValue, s1);

    curReq = "R8";
    clrFlag(0); chk("R8 zero write no effect", capFlag, 1);
    clrFlag(1); chk("R8 one clears", capFlag, 0);

    curReq = "R10";
    s2 = capValue;
    pinTo(0); pinTo(1);
    chk("R10 shift on overwrite", holdValue, s2);
    chk("R10 flag", capFlag, 1);

    curReq = "R3";
    clrFlag(1);
    setMode(2'b10);
    pinTo(0);
    chk("R3 first edge after mode write silent", capFlag, 0);
    pinTo(1);
    chk("R2 rising ignored in fall mode", capFlag, 0);

    curReq = "R2";
    setMode(2'b11);
    pinTo(0); chk("R2 any mode first", capFlag, 0);
    pinTo(1); chk("R2 any mode second", capFlag, 1);

    curReq = "R6";
    clrFlag(1);
    noOverwrite = 1;
    setMode(2'b01);
    pinTo(0); pinTo(1); pinTo(0); pinTo(1);
    chk("R6 filled", capFlag, 1);
    c = capValue; h = holdValue;
    pinTo(0); pinTo(1);
    chk("R6 blocked cap", capValue, c); chk("R6 blocked hold", holdValue, h);
    rdCap();
    pinTo(0); pinTo(1);
    chk("R6 one read still blocked", capValue, c);
    curReq = "R9";
    clrFlag(1);
    rdHold();
    pinTo(0); pinTo(1);
    chk("R7 drained queue first edge silent", capFlag, 0);
    pinTo(0); pinTo(1);
    chk("R9 flag sets after clear-read order", capFlag, 1);
    rdHold(); rdCap();
    pinTo(0); pinTo(1);
    clrFlag(1);
    pinTo(0); pinTo(1);
    chk("R9 flag sets after read-edge-clear order", capFlag, 1);
    clrFlag(1);
    pinTo(0); pinTo(1);
    rdCap(); rdHold();
    pinTo(0); pinTo(1);
    pinTo(0); pinTo(1);
    chk("R9 flag after clear-edge-reads", capFlag, 1);

    curReq = "R7";
    noOverwrite = 0;
    clrFlag(1);
    setMode(2'b01);
    pinTo(0); pinTo(1);
    h = holdValue;
    pinIn = 0; @(negedge clk); pinIn = 1; @(negedge clk); @(negedge clk);
    // edge lands on capture edge together with the read
    pinIn = 1; repeat (0) @(negedge clk);
    capRdStb = 1; @(negedge clk); capRdStb = 0;
    repeat (4) @(negedge clk);
    chk("R7 same cycle read keeps hold", holdValue, h);
    chk("R7 same cycle read no flag", capFlag, 0);

    curReq = "R8";
    pinIn = 0; repeat (5) @(negedge clk);
    pinIn = 1; @(negedge clk); @(negedge clk);
    flagClrData = 1; flagClrWr = 1; @(negedge clk); flagClrWr = 0;
    repeat (3) @(negedge clk);
    chk("R8 set wins over clear", capFlag, 1);

    curReq = "R3";
    clrFlag(1);
    setMode(2'b01);
    c = capValue;
    pinIn = 0; repeat (5) @(negedge clk);
    pinIn = 1; @(negedge clk); @(negedge clk);
    setMode(2'b01);
    repeat (3) @(negedge clk);
    chk("R3 edge dropped on mode write", capValue, c);
    pinTo(0); pinTo(1);
    chk("R3 next edge is first", capFlag, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule